// File: doc/BRIEF.md
# Programmable Nested Loop Sequencer

This block runs counted loops in hardware so that a microcoded datapath needs no branch instructions for them. Software first writes a loop description into one of several context slots in a single cycle. The description holds a first count, a last count, a stride and an initiation interval. A launch command then makes that context the running loop. The block admits one loop body every initiation-interval cycles and advances the loop counter by the stride at each step. Moving on to the next iteration costs no idle cycles.

A launch issued while a loop is already running nests the new loop inside it. The enclosing context index is pushed onto a small stack. The counters of the enclosing loops stay frozen and remain visible on the exported counter bus, so consumers such as address generators can keep using them. When the inner loop completes, the block emits a one-cycle completion pulse and returns to the enclosing loop. That loop then takes its own next step, or completes in turn.

Top module: `nested_loop_unit`

## Requirements
- R1: A write with `cfg_we` high stores first, last, stride and interval into the context selected by `cfg_sel` at one clock edge. A later launch of that context uses these values.
- R2: After synchronous reset, `busy`, `body_start`, `loop_done` and `cfg_err` are 0, `nest_level` is 0 and every counter slice of `counts` is 0.
- R3: A launch (`go` high with `go_sel` = c) loads counter c with its first value at the next edge. `body_start` is high in the cycle after the launch cycle. Counter c is exported on `counts[16*c +: 16]`.
- R4: While a loop runs, `body_start` is high in exactly one cycle out of every interval cycles. The counter advances by the stride at each interval boundary, with no gap cycles between iterations.
- R5: `loop_done` is high for one cycle: the last cycle of the iteration whose counter plus stride, computed without wrap-around, exceeds the last value. In that case the counter is not advanced. At the outermost level, `busy` falls at the next edge.
- R6: A launch while busy pushes the running context. `nest_level` rises by one, `cur_ctx` shows the new context, and the enclosing counter holds its value and stays readable.
- R7: When an inner loop completes, the enclosing loop is resumed with one evaluation cycle that admits no body. It then advances by its own stride, so its next `body_start` comes in the following cycle.
- R8: A configuration write to a context that is running or stacked is ignored, and `cfg_err` is high in the next cycle. A write to an idle context leaves `cfg_err` low.
- R9: A launch naming a context that is already running or stacked is ignored. Nesting level and counters are unaffected.
- R10: An interval value of 0 behaves as an interval of 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Context write strobe |
| cfg_sel | input | 2 | Context written |
| cfg_first | input | 16 | First counter value |
| cfg_last | input | 16 | Last allowed counter value |
| cfg_stride | input | 16 | Counter increment |
| cfg_ii | input | 4 | Cycles per iteration (initiation interval) |
| go | input | 1 | Launch command |
| go_sel | input | 2 | Context to launch |
| body_start | output | 1 | A new loop body is admitted this cycle |
| loop_done | output | 1 | Final cycle of the running loop |
| cfg_err | output | 1 | Previous cycle's write hit an active context |
| busy | output | 1 | A loop is running |
| cur_ctx | output | 2 | Context currently stepping |
| nest_level | output | 3 | Number of stacked enclosing loops |
| counts | output | 64 | All context counters, context c in bits 16*c+15 down to 16*c |

## Verification
The embedded properties assume that every launched context has first not above last and a nonzero stride. They also assume that software never writes a context in the same cycle it launches it. The range property on the running counter depends on the first assumption. The bench only programs descriptions that meet these conditions, including the case whose final count sits next to the top of the 16-bit range. An interval of zero is the one deliberate exception, and it falls under R10. Launches of active contexts and writes to locked contexts are issued at chosen cycles while a loop runs, never in the cycle of a completion pulse.

// File: rtl/nlu_pkg.sv
package nlu_pkg;

    localparam int CW  = 16;
    localparam int IIW = 4;

    typedef logic [CW-1:0]  cnt_t;
    typedef logic [IIW-1:0] ii_t;

    typedef struct packed {
        cnt_t first;
        cnt_t last;
        cnt_t stride;
        ii_t  ii;
    } loop_desc_t;

    function automatic ii_t norm_ii(ii_t v);
        return (v == '0) ? ii_t'(1) : v;
    endfunction

    function automatic logic step_overruns(cnt_t c, cnt_t s, cnt_t e);
        logic [CW:0] sum;
        sum = {1'b0, c} + {1'b0, s};
        return sum > {1'b0, e};
    endfunction

endpackage

// File: rtl/nlu_ctx_bank.sv
module nlu_ctx_bank
    import nlu_pkg::*;
#(
    parameter int NCTX = 4,
    localparam int XW = $clog2(NCTX)
)(
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [XW-1:0]    widx,
    input  loop_desc_t       wdesc,
    input  logic [NCTX-1:0]  lock,
    output loop_desc_t       descs [NCTX],
    output logic             err
);

    loop_desc_t regs [NCTX];

    for (genvar i = 0; i < NCTX; i++) begin : g_ctx
        always_ff @(posedge clk) begin
            if (rst)
                regs[i] <= '0;
            else if (we && widx == XW'(i) && !lock[i])
                regs[i] <= wdesc;
        end
        assign descs[i] = regs[i];

        assert_locked_hold_R8: assert property (@(posedge clk) disable iff (rst)
            (we && widx == XW'(i) && lock[i]) |=> $stable(regs[i]));
    end

    always_ff @(posedge clk) begin
        if (rst) err <= 1'b0;
        else     err <= we && lock[widx];
    end

endmodule

// File: rtl/nlu_stack.sv
module nlu_stack #(
    parameter int DEPTH = 4,
    parameter int IW    = 2,
    localparam int LW   = $clog2(DEPTH + 1),
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
)(
    input  logic          clk,
    input  logic          rst,
    input  logic          push,
    input  logic          pop,
    input  logic [IW-1:0] din,
    output logic [IW-1:0] top,
    output logic [LW-1:0] level
);

    logic [IW-1:0] mem [DEPTH];
    logic [LW-1:0] tpos;

    assign tpos = level - LW'(1);
    assign top  = (level == '0) ? '0 : mem[tpos[AW-1:0]];

    always_ff @(posedge clk) begin
        if (rst) begin
            level <= '0;
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (push && level < LW'(DEPTH)) begin
            mem[level[AW-1:0]] <= din;
            level <= level + LW'(1);
        end else if (pop && level != '0) begin
            level <= level - LW'(1);
        end
    end

    assert_level_bound_R6: assert property (@(posedge clk) disable iff (rst)
        level <= LW'(DEPTH));

    assert_push_top_R6: assert property (@(posedge clk) disable iff (rst)
        (push && level < LW'(DEPTH)) |=> (top == $past(din)));

endmodule

// File: rtl/nested_loop_unit.sv
module nested_loop_unit
    import nlu_pkg::*;
#(
    parameter int NCTX  = 4,
    parameter int DEPTH = 4,
    localparam int XW = $clog2(NCTX),
    localparam int LW = $clog2(DEPTH + 1)
)(
    input  logic               clk,
    input  logic               rst,
    input  logic               cfg_we,
    input  logic [XW-1:0]      cfg_sel,
    input  logic [CW-1:0]      cfg_first,
    input  logic [CW-1:0]      cfg_last,
    input  logic [CW-1:0]      cfg_stride,
    input  logic [IIW-1:0]     cfg_ii,
    input  logic               go,
    input  logic [XW-1:0]      go_sel,
    output logic               body_start,
    output logic               loop_done,
    output logic               cfg_err,
    output logic               busy,
    output logic [XW-1:0]      cur_ctx,
    output logic [LW-1:0]      nest_level,
    output logic [NCTX*CW-1:0] counts
);

    loop_desc_t      descs [NCTX];
    loop_desc_t      wdesc;
    cnt_t            cnt_q [NCTX];
    logic [NCTX-1:0] act_q;
    logic [XW-1:0]   cur_q;
    logic [XW-1:0]   stk_top;
    ii_t             phase_q;
    logic            busy_q;
    logic            resume_q;

    ii_t  cur_ii;
    logic at_bound;
    logic last_iter;
    logic go_ok;
    logic push;
    logic pop;
    cnt_t outer_cnt;

    assign wdesc = '{first: cfg_first, last: cfg_last, stride: cfg_stride, ii: cfg_ii};

    nlu_ctx_bank #(.NCTX(NCTX)) u_bank (
        .clk   (clk),
        .rst   (rst),
        .we    (cfg_we),
        .widx  (cfg_sel),
        .wdesc (wdesc),
        .lock  (act_q),
        .descs (descs),
        .err   (cfg_err)
    );

    nlu_stack #(.DEPTH(DEPTH), .IW(XW)) u_stack (
        .clk   (clk),
        .rst   (rst),
        .push  (push),
        .pop   (pop),
        .din   (cur_q),
        .top   (stk_top),
        .level (nest_level)
    );

    always_comb begin
        cur_ii     = norm_ii(descs[cur_q].ii);
        at_bound   = busy_q && (phase_q == ii_t'(cur_ii - ii_t'(1)));
        last_iter  = step_overruns(cnt_q[cur_q], descs[cur_q].stride, descs[cur_q].last);
        go_ok      = go && !act_q[go_sel];
        body_start = busy_q && phase_q == '0 && !resume_q;
        loop_done  = at_bound && last_iter && !go_ok;
        push       = go_ok && busy_q;
        pop        = loop_done && nest_level != '0;
        outer_cnt  = cnt_q[stk_top];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q   <= 1'b0;
            cur_q    <= '0;
            phase_q  <= '0;
            act_q    <= '0;
            resume_q <= 1'b0;
            for (int i = 0; i < NCTX; i++) cnt_q[i] <= '0;
        end else if (go_ok) begin
            cnt_q[go_sel] <= descs[go_sel].first;
            cur_q         <= go_sel;
            phase_q       <= '0;
            busy_q        <= 1'b1;
            act_q[go_sel] <= 1'b1;
            resume_q      <= 1'b0;
        end else if (loop_done) begin
            act_q[cur_q] <= 1'b0;
            if (nest_level != '0) begin
                cur_q    <= stk_top;
                phase_q  <= ii_t'(norm_ii(descs[stk_top].ii) - ii_t'(1));
                resume_q <= 1'b1;
            end else begin
                busy_q   <= 1'b0;
                phase_q  <= '0;
                resume_q <= 1'b0;
            end
        end else if (at_bound) begin
            cnt_q[cur_q] <= cnt_t'(cnt_q[cur_q] + descs[cur_q].stride);
            phase_q      <= '0;
            resume_q     <= 1'b0;
        end else if (busy_q) begin
            phase_q  <= phase_q + ii_t'(1);
            resume_q <= 1'b0;
        end
    end

    assign busy    = busy_q;
    assign cur_ctx = cur_q;

    for (genvar i = 0; i < NCTX; i++) begin : g_out
        assign counts[i*CW +: CW] = cnt_q[i];
    end

    assert_cnt_in_range_R5: assert property (@(posedge clk) disable iff (rst)
        busy_q |-> (cnt_q[cur_q] <= descs[cur_q].last));

    assert_outer_frozen_R6: assert property (@(posedge clk) disable iff (rst)
        (busy_q && nest_level != '0 && !loop_done && !go) |=> $stable(outer_cnt));

    assert_pop_resume_R7: assert property (@(posedge clk) disable iff (rst)
        (loop_done && nest_level != '0) |=>
            (nest_level == LW'($past(nest_level) - LW'(1))) && !body_start);

endmodule

// File: tb/nested_loop_unit_bench.sv
module nested_loop_unit_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_sel = '0;
    logic [15:0] cfg_first = '0, cfg_last = '0, cfg_stride = '0;
    logic [3:0]  cfg_ii = '0;
    logic        go = 1'b0;
    logic [1:0]  go_sel = '0;
    logic        body_start, loop_done, cfg_err, busy;
    logic [1:0]  cur_ctx;
    logic [2:0]  nest_level;
    logic [63:0] counts;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    nested_loop_unit u_nested_loop_unit (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_first(cfg_first), .cfg_last(cfg_last), .cfg_stride(cfg_stride),
        .cfg_ii(cfg_ii), .go(go), .go_sel(go_sel), .body_start(body_start),
        .loop_done(loop_done), .cfg_err(cfg_err), .busy(busy), .cur_ctx(cur_ctx),
        .nest_level(nest_level), .counts(counts)
    );

    function automatic int cnt_of(int c);
        return int'(counts[c*16 +: 16]);
    endfunction

    task automatic chk(input string rq, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
        end
    endtask

    task automatic report;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    endtask

    task automatic cfg_write(input int c, input int s, input int e, input int k, input int ii);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = 2'(c);
        cfg_first = 16'(s); cfg_last = 16'(e); cfg_stride = 16'(k); cfg_ii = 4'(ii);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // R1 R3 R4 R5 R10: a single loop, checked cycle by cycle against arithmetic
    task automatic run_single(input int c, input int s, input int e, input int k,
                              input int iic, input int iie, input bit docfg);
        int n;
        int kk;
        int ph;
        if (docfg) cfg_write(c, s, e, k, iic);
        n = (e - s) / k + 1;
        @(negedge clk);
        go = 1'b1; go_sel = 2'(c);
        for (int t = 1; t <= n * iie + 1; t++) begin
            @(negedge clk);
            go = 1'b0;
            if (t <= n * iie) begin
                kk = (t - 1) / iie;
                ph = (t - 1) % iie;
                chk("R3/R4 busy", int'(busy), 1);
                chk("R4 body_start", int'(body_start), (ph == 0) ? 1 : 0);
                chk("R1/R4 count", cnt_of(c), s + kk * k);
                chk("R5 loop_done", int'(loop_done), (t == n * iie) ? 1 : 0);
                chk("R10 ctx", int'(cur_ctx), c);
            end else begin
                chk("R5 busy drop", int'(busy), 0);
                chk("R5 body idle", int'(body_start), 0);
                chk("R5 count held", cnt_of(c), s + (n - 1) * k);
            end
        end
    endtask

    initial begin
        int ctx;
        int outer_b;
        int inner_b;
        int dones;
        int last_outer_t;
        int inner_idx;
        int t;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R2 reset state
        chk("R2 busy", int'(busy), 0);
        chk("R2 body_start", int'(body_start), 0);
        chk("R2 loop_done", int'(loop_done), 0);
        chk("R2 cfg_err", int'(cfg_err), 0);
        chk("R2 nest_level", int'(nest_level), 0);
        for (int c = 0; c < 4; c++) chk("R2 counts", cnt_of(c), 0);

        // sweep of intervals, strides and ranges (including top-of-range R5)
        ctx = 0;
        for (int ii = 1; ii <= 4; ii++)
            for (int k = 1; k <= 3; k++)
                for (int r = 0; r < 3; r++) begin
                    case (r)
                        0: run_single(ctx, 0, 0, k, ii, ii, 1'b1);
                        1: run_single(ctx, 3, 9, k, ii, ii, 1'b1);
                        default: run_single(ctx, 65530, 65535, k + 2, ii, ii, 1'b1);
                    endcase
                    ctx = (ctx + 1) % 4;
                end

        // R10: interval 0 acts as 1
        run_single(3, 1, 3, 1, 0, 1, 1'b1);

        // R6 R7: nested loops
        cfg_write(0, 0, 2, 1, 2);
        cfg_write(1, 10, 12, 1, 1);
        @(negedge clk);
        go = 1'b1; go_sel = 2'd0;
        outer_b = 0; inner_b = 0; dones = 0; last_outer_t = -1; inner_idx = 0;
        t = 0;
        @(negedge clk);
        go = 1'b0;
        while (busy && t < 200) begin
            t++;
            if (loop_done) dones++;
            if (body_start && cur_ctx == 2'd0) begin
                if (last_outer_t >= 0) chk("R7 outer body spacing", t - last_outer_t, 5);
                chk("R7 outer count", cnt_of(0), outer_b);
                chk("R6 level outer", int'(nest_level), 0);
                last_outer_t = t;
                outer_b++;
                inner_idx = 0;
                go = 1'b1; go_sel = 2'd1;
            end else begin
                go = 1'b0;
            end
            if (body_start && cur_ctx == 2'd1) begin
                chk("R6 level inner", int'(nest_level), 1);
                chk("R6 outer counter visible", cnt_of(0), outer_b - 1);
                chk("R6 inner count", cnt_of(1), 10 + inner_idx);
                inner_idx++;
                inner_b++;
            end
            @(negedge clk);
        end
        go = 1'b0;
        chk("R7 outer bodies", outer_b, 3);
        chk("R6 inner bodies", inner_b, 9);
        chk("R5 done pulses", dones, 4);
        chk("R7 final outer count", cnt_of(0), 2);
        chk("R6 final inner count", cnt_of(1), 12);
        chk("R7 level back", int'(nest_level), 0);

        // R8 R9: writes and launches aimed at an active context
        cfg_write(2, 0, 20, 1, 1);
        @(negedge clk);
        go = 1'b1; go_sel = 2'd2;          // cycle 0
        @(negedge clk); go = 1'b0;          // cycle 1
        @(negedge clk);                     // cycle 2
        go = 1'b1; go_sel = 2'd2;           // relaunch of active context
        @(negedge clk); go = 1'b0;          // cycle 3
        chk("R9 relaunch ignored count", cnt_of(2), 2);
        chk("R9 relaunch ignored level", int'(nest_level), 0);
        cfg_we = 1'b1; cfg_sel = 2'd2;
        cfg_first = 16'd7; cfg_last = 16'd8; cfg_stride = 16'd1; cfg_ii = 4'd3;
        @(negedge clk);                     // cycle 4
        cfg_we = 1'b0;
        chk("R8 err after locked write", int'(cfg_err), 1);
        chk("R8 count unaffected", cnt_of(2), 3);
        cfg_we = 1'b1; cfg_sel = 2'd3;
        cfg_first = 16'd4; cfg_last = 16'd6; cfg_stride = 16'd2; cfg_ii = 4'd2;
        @(negedge clk);                     // cycle 5
        cfg_we = 1'b0;
        chk("R8 no err on idle ctx", int'(cfg_err), 0);
        t = 0;
        while (busy && t < 100) begin
            @(negedge clk);
            t++;
        end
        chk("R8 run ended", int'(busy), 0);
        run_single(2, 0, 20, 1, 1, 1, 1'b0);   // ctx 2 kept its original description
        run_single(3, 4, 6, 2, 2, 2, 1'b0);    // ctx 3 took the idle-time write

        report();
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog (R1..R10 run) actual=hang expected=finish");
        report();
        $finish;
    end

endmodule